// File: doc/BRIEF.md
# Dual-Slope Phase-Frequency Detector

This block compares two edge streams, a reference and a feedback, inside a fast sampling clock domain. It produces a fine lead/lag pulse pair whose width in sampling cycles equals the measured phase error. It also produces a coarse pair that switches on only for the portion of a large error that lasts beyond a programmable threshold. A downstream charge-pump model weights the coarse pair four times as heavily as the fine pair. Near lock the gain is therefore that of a plain linear detector, and far from lock the gain is steeper, which shortens acquisition.

Both inputs pass through a two-flop synchronizer before a rising-edge detector. The first rising edge of either stream opens a pulse. The first edge of the other stream closes it, and the detector returns to idle. A signed net-drive value sums the four outputs with their weights every cycle, so the charge delivered over one comparison can be read directly.

Top module: `dual_slope_pfd`

## Requirements
- R1: While reset is held and directly after it, `lead_fine`, `lag_fine`, `lead_coarse` and `lag_coarse` are 0 and `net_drive` is 0.
- R2: A rising edge on `ref_in` that the sampling clock picks up at one rising clock edge makes `lead_fine` go high at the third rising clock edge counted from that one. A rising edge on `fb_in` acts on `lag_fine` with the same delay.
- R3: Suppose the rising edge of one input precedes the rising edge of the other by d sampling cycles, with d at least 1. The matching fine output (`lead_fine` when the reference leads, `lag_fine` when the feedback leads) is then high for exactly d cycles. The opposite fine output never pulses, and the two fine outputs are never high in the same cycle.
- R4: Let thr be the effective threshold, and let d exceed thr. The matching coarse output is high for exactly d − thr cycles. It rises thr cycles after its fine output rises and falls in the same cycle as that fine output. A coarse output is only ever high while its own fine output is high.
- R5: When d is at most the effective threshold, both coarse outputs remain 0 for the whole comparison.
- R6: `net_drive` is a 4-bit two's-complement value equal to (lead_fine − lag_fine) + 4·(lead_coarse − lag_coarse). Summed over one comparison, it equals +(d + 4·max(0, d − thr)) when the reference leads and the negative of that when the feedback leads.
- R7: When both inputs rise in the same sampling cycle, none of the four pulse outputs goes high and `net_drive` stays 0.
- R8: `thresh` holds the threshold as an unsigned count of sampling cycles. A value of 0 is treated as 1.
- R9: Further rising edges of the leading input that arrive while its fine output is already high have no effect. The pulse width is still measured from the first edge up to the edge of the other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference edge stream (asynchronous) |
| fb_in | input | 1 | Feedback edge stream (asynchronous) |
| thresh | input | 8 | Coarse threshold in sampling cycles |
| lead_fine | output | 1 | Fine pulse, reference leads |
| lag_fine | output | 1 | Fine pulse, feedback leads |
| lead_coarse | output | 1 | Coarse pulse, reference leads by more than the threshold |
| lag_coarse | output | 1 | Coarse pulse, feedback leads by more than the threshold |
| net_drive | output | 4 | Signed weighted sum of the four pulses |

## Verification
An input edge reaches the fine outputs three rising clock edges after the synchronizer first samples it. The closing edge clears the pair after the same three edges, so the pulse width is exactly the input spacing. Coarse outputs change in the same registered stage as the fine ones, and `net_drive` is combinational from those registers. Each scenario drives its inputs on falling clock edges and samples all outputs on the falling edges that follow. It accumulates widths and the drive sum over a window that runs well past the closing edge, and it checks the latency case at the second and third sampled cycle after the drive.

// File: rtl/dual_slope_pfd.sv
module dual_slope_pfd #(
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 8,
  parameter int COARSE_GAIN = 4,
  parameter int DRIVE_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ref_in,
  input  logic                      fb_in,
  input  logic [THR_W-1:0]          thresh,
  output logic                      lead_fine,
  output logic                      lag_fine,
  output logic                      lead_coarse,
  output logic                      lag_coarse,
  output logic signed [DRIVE_W-1:0] net_drive
);

  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] THR_MIN = THR_W'(1);

  logic [SYNC_STAGES-1:0] ref_sync, fb_sync;
  logic ref_last, fb_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_sync <= '0;
      fb_sync  <= '0;
      ref_last <= 1'b0;
      fb_last  <= 1'b0;
    end else begin
      ref_sync <= {ref_sync[SYNC_STAGES-2:0], ref_in};
      fb_sync  <= {fb_sync[SYNC_STAGES-2:0], fb_in};
      ref_last <= ref_sync[SYNC_STAGES-1];
      fb_last  <= fb_sync[SYNC_STAGES-1];
    end

  wire ref_rise = ref_sync[SYNC_STAGES-1] & ~ref_last;
  wire fb_rise  = fb_sync[SYNC_STAGES-1] & ~fb_last;

  wire up_set = lead_fine | ref_rise;
  wire dn_set = lag_fine  | fb_rise;
  wire clear  = up_set & dn_set;

  wire [THR_W-1:0] thr_eff = (thresh == '0) ? THR_MIN : thresh;

  logic [THR_W-1:0] elapsed;
  wire  [THR_W-1:0] elapsed_nx = (elapsed == CNT_MAX) ? elapsed : elapsed + THR_W'(1);
  wire              over_thr   = elapsed_nx >= thr_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lead_fine   <= 1'b0;
      lag_fine    <= 1'b0;
      lead_coarse <= 1'b0;
      lag_coarse  <= 1'b0;
      elapsed     <= '0;
    end else if (clear) begin
      lead_fine   <= 1'b0;
      lag_fine    <= 1'b0;
      lead_coarse <= 1'b0;
      lag_coarse  <= 1'b0;
      elapsed     <= '0;
    end else begin
      lead_fine   <= up_set;
      lag_fine    <= dn_set;
      lead_coarse <= lead_coarse | (lead_fine & over_thr);
      lag_coarse  <= lag_coarse  | (lag_fine  & over_thr);
      if (lead_fine | lag_fine) elapsed <= elapsed_nx;
    end

  wire signed [DRIVE_W-1:0] fine_term =
    DRIVE_W'($signed({1'b0, lead_fine}) - $signed({1'b0, lag_fine}));
  wire signed [DRIVE_W-1:0] coarse_term =
    DRIVE_W'(($signed({1'b0, lead_coarse}) - $signed({1'b0, lag_coarse})) * COARSE_GAIN);
  assign net_drive = fine_term + coarse_term;

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_fine && lag_fine));

  assert_lead_coarse_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lead_coarse |-> lead_fine);

  assert_lag_coarse_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lag_coarse |-> lag_fine);

  assert_coarse_after_fine_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lead_fine) |-> !lead_coarse);

  assert_same_cycle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise && !lead_fine && !lag_fine) |=> (!lead_fine && !lag_fine));

  assert_drive_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_fine |-> (net_drive > 0));

endmodule

// File: tb/dual_slope_pfd_tb_top.sv
module dual_slope_pfd_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [7:0] thresh = 8'd8;
  logic lead_fine, lag_fine, lead_coarse, lag_coarse;
  logic signed [3:0] net_drive;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dual_slope_pfd dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .thresh(thresh),
    .lead_fine(lead_fine), .lag_fine(lag_fine), .lead_coarse(lead_coarse),
    .lag_coarse(lag_coarse), .net_drive(net_drive));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_case(input string req, input bit ref_leads, input int d, input int thr);
    int nu = 0, nd = 0, nuc = 0, ndc = 0, sum = 0;
    int eff, co, integ;
    thresh = thr[7:0];
    @(negedge clk);
    if (d == 0) begin ref_in = 1'b1; fb_in = 1'b1; end
    else if (ref_leads) ref_in = 1'b1;
    else fb_in = 1'b1;
    for (int i = 1; i <= 320; i++) begin
      @(negedge clk);
      nu += lead_fine; nd += lag_fine; nuc += lead_coarse; ndc += lag_coarse;
      sum += int'(net_drive);
      if (i == d) begin ref_in = 1'b1; fb_in = 1'b1; end
    end
    eff = (thr == 0) ? 1 : thr;
    co = (d > eff) ? d - eff : 0;
    integ = d + 4 * co;
    check({req, " lead_fine width"}, nu, ref_leads ? d : 0);
    check({req, " lag_fine width"}, nd, ref_leads ? 0 : d);
    check({req, " lead_coarse width"}, nuc, ref_leads ? co : 0);
    check({req, " lag_coarse width"}, ndc, ref_leads ? 0 : co);
    check({req, " R6 drive integral"}, sum, ref_leads ? integ : -integ);
    settle();
  endtask

  task automatic test_reset();
    check("R1 lead_fine", lead_fine, 0);
    check("R1 lag_fine", lag_fine, 0);
    check("R1 coarse", lead_coarse | lag_coarse, 0);
    check("R1 net_drive", int'(net_drive), 0);
  endtask

  task automatic test_latency();
    thresh = 8'd50;
    @(negedge clk);
    ref_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 lead_fine before third edge", lead_fine, 0);
    @(negedge clk);
    check("R2 lead_fine at third edge", lead_fine, 1);
    fb_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 lag path still clear", lag_fine, 0);
    @(negedge clk);
    check("R2 fine pair closed three edges after feedback", lead_fine | lag_fine, 0);
    settle();
  endtask

  task automatic test_extra_edges();
    int nu = 0, nd = 0;
    thresh = 8'd40;
    @(negedge clk);
    ref_in = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      nu += lead_fine; nd += lag_fine;
      if (i == 4) ref_in = 1'b0;
      if (i == 8) ref_in = 1'b1;
      if (i == 14) fb_in = 1'b1;
    end
    check("R9 width from first edge", nu, 14);
    check("R9 no lag pulse", nd, 0);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_latency();
    run_case("R3 R5 small ref lead", 1'b1, 5, 10);
    run_case("R4 large ref lead", 1'b1, 12, 4);
    run_case("R4 large fb lead", 1'b0, 9, 3);
    run_case("R5 lag equal threshold", 1'b1, 7, 7);
    run_case("R4 one past threshold", 1'b0, 8, 7);
    run_case("R3 single cycle", 1'b1, 1, 1);
    run_case("R7 simultaneous", 1'b1, 0, 5);
    run_case("R8 zero threshold", 1'b1, 6, 0);
    run_case("R4 max threshold long lag", 1'b0, 300, 255);
    test_extra_edges();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule